// File: doc/BRIEF.md
# Removable Card Presence Monitor with Insertion Reset

This block watches the two active-low contact-sense lines of a removable storage socket and decides whether a card is seated. A card counts as present only when both lines read low. A card that is partly inserted, with one contact still open, counts as absent. Both lines, and the card's two ready lines, pass through a flop synchronizer before any decision uses them. Presence is then held in a registered flag.

Every change of presence, in either direction, raises a one-cycle event pulse for a downstream interrupt collector. It also sets a sticky change flag that software clears with a one-cycle clear strobe. When a card becomes present, the block drives a reset pulse to the card. The pulse length is set in microseconds and converted to clock cycles. A software request line also forces the card reset for as long as it is held. After a controller reset, the block first lets its synchronizers fill, then adopts the pin state silently. A card already seated at power-up therefore gets no event and no extra reset pulse.

Top module: `cpd_card_detect`

## Requirements
- R1: `card_present` is 1 only when both synchronized detect inputs are low. Any detect input at 1 means absent.
- R2: A change from absent to present starts a reset pulse on `card_reset`. The pulse starts one cycle after `det_event` and lasts exactly `PULSE_US*CLK_HZ/1e6` cycles. No other presence change starts a pulse.
- R3: Each change of presence gives `det_event` high for exactly one cycle. No pulse is raised while presence is unchanged, including when only one pin toggles while the other stays high.
- R4: A change on the detect pins shows on `card_present` and `det_event` at the third rising edge after it is applied, with the default two synchronizer stages.
- R5: Status word layout:
  - bit 0 is the sticky change flag. It is set with each `det_event` and cleared by `chg_clr`; a set wins over a clear in the same cycle.
  - bit 2 is the synchronized level of `det1_n`.
  - bit 3 is the synchronized level of `det2_n`.
  - bit 5 is the synchronized card-ready input.
  - bit 6 is the synchronized I/O-ready input.
  - bits 1, 4 and 7 read 0.
  - The level bits follow their pins after two rising edges.
- R6: While `sw_rst_req` is 1, `card_reset` is 1 in the same cycle.
- R7: A removal during a running reset pulse ends the pulse. `card_reset` is low one cycle after the removal event (unless `sw_rst_req` is high).
- R8: After `rst_n` is released with a card already seated, `card_present` becomes 1 without any `det_event` and without a reset pulse.
- R9: During reset, `card_present`, `det_event` and `card_reset` (with `sw_rst_req` low) are 0. With the ready inputs low, `status` reads 8'h0C.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| det1_n | input | 1 | First contact-sense line, low when seated |
| det2_n | input | 1 | Second contact-sense line, low when seated |
| card_rdy | input | 1 | Card ready line from the socket |
| io_rdy | input | 1 | I/O ready line from the socket |
| sw_rst_req | input | 1 | Software card-reset request, level |
| chg_clr | input | 1 | One-cycle clear of the sticky change flag |
| card_present | output | 1 | Registered presence flag |
| det_event | output | 1 | One-cycle presence-change pulse |
| card_reset | output | 1 | Reset drive to the card |
| status | output | 8 | Status word |

## Verification
The bench walks every pair of old and new pin states, all sixteen. For each pair it checks:
- that presence follows both lines being low, so a design that ORs the lines would flag partial insertions;
- that the event appears once and only on a real change, so an edge detector on a single pin would fire wrongly;
- that the reset pulse follows insertions only and has exactly the programmed length, so an off-by-one counter is caught.

Further tests cover these cases:
- A card seated through a controller reset must produce neither an event nor a pulse. A design that compares against the reset value of the synchronizer would emit both.
- A removal in the middle of a pulse must end the pulse.
- A clear strobe that coincides with a new event must lose to it, or a change would be silently dropped.

// File: rtl/cpd_pkg.sv
package cpd_pkg;
  localparam int STS_W     = 8;
  localparam int STS_CHG   = 0;
  localparam int STS_DET1  = 2;
  localparam int STS_DET2  = 3;
  localparam int STS_CRDY  = 5;
  localparam int STS_IORDY = 6;

  typedef struct packed {
    logic present;
    logic change;
    logic insert;
    logic remove;
  } cpd_pres_t;
endpackage

// File: rtl/cpd_sync.sv
module cpd_sync #(
  parameter int               WIDTH   = 4,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg_q [STAGES];
  logic [WIDTH-1:0] stg_d [STAGES];

  always_comb begin
    stg_d[0] = d;
    for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
  end

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[g] <= RST_VAL;
        else        stg_q[g] <= stg_d[g];
      end
    end
  endgenerate

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/cpd_presence.sv
module cpd_presence
  import cpd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      det1_s,
  input  logic      det2_s,
  input  logic      chg_clr,
  output cpd_pres_t pres,
  output logic      chg_flag
);
  localparam int SETTLE = SYNC_STAGES + 1;
  localparam int CW     = $clog2(SETTLE + 1);

  logic [CW-1:0] settle_q, settle_d;
  logic          present_q, present_d;
  logic          event_q, event_d;
  logic          ins_q, ins_d;
  logic          rm_q, rm_d;
  logic          chg_q, chg_d;
  logic          both_low, armed, differs;

  always_comb begin
    both_low  = ~det1_s & ~det2_s;
    armed     = (settle_q == CW'(SETTLE));
    differs   = both_low ^ present_q;
    settle_d  = armed ? settle_q : settle_q + CW'(1);
    present_d = both_low;
    event_d   = armed & differs;
    ins_d     = armed & differs & both_low;
    rm_d      = armed & differs & ~both_low;
    chg_d     = event_d | (chg_q & ~chg_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      settle_q  <= '0;
      present_q <= 1'b0;
      event_q   <= 1'b0;
      ins_q     <= 1'b0;
      rm_q      <= 1'b0;
      chg_q     <= 1'b0;
    end else begin
      settle_q  <= settle_d;
      present_q <= present_d;
      event_q   <= event_d;
      ins_q     <= ins_d;
      rm_q      <= rm_d;
      chg_q     <= chg_d;
    end
  end

  assign pres.present = present_q;
  assign pres.change  = event_q;
  assign pres.insert  = ins_q;
  assign pres.remove  = rm_q;
  assign chg_flag     = chg_q;

  // R3: an armed presence change always comes with an event
  p_event_on_change_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && (present_q != $past(present_q)) && ($past(settle_q) == CW'(SETTLE)))
      |-> event_q);

  // R2: an insertion marker is only raised with presence and an event
  p_insert_is_present_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ins_q |-> (present_q && event_q && !rm_q));

  // R8: no event while the synchronizers are still filling
  p_quiet_settle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> !event_q);
endmodule

// File: rtl/cpd_rst_timer.sv
module cpd_rst_timer #(
  parameter int RST_CYCLES = 20000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  output logic busy
);
  localparam int CW = $clog2(RST_CYCLES + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (start)              cnt_d = CW'(RST_CYCLES);
    else if (abort)         cnt_d = '0;
    else if (cnt_q != '0)   cnt_d = cnt_q - CW'(1);
    else                    cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);

  // R2: a pulse always begins at its full length
  p_load_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (cnt_q == CW'(RST_CYCLES)));

  // R2: while running and undisturbed the count falls by one
  p_count_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start && !abort) |=> (cnt_q == $past(cnt_q) - CW'(1)));

  // R7: a removal ends the pulse on the next cycle
  p_abort_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && !start) |=> !busy);
endmodule

// File: rtl/cpd_card_detect.sv
module cpd_card_detect
  import cpd_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 100_000_000,
  parameter int unsigned PULSE_US    = 200,
  parameter int          SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             det1_n,
  input  logic             det2_n,
  input  logic             card_rdy,
  input  logic             io_rdy,
  input  logic             sw_rst_req,
  input  logic             chg_clr,
  output logic             card_present,
  output logic             det_event,
  output logic             card_reset,
  output logic [STS_W-1:0] status
);
  localparam int RST_CYCLES = int'((CLK_HZ / 1_000_000) * PULSE_US);
  localparam int NSYNC      = 4;

  logic [NSYNC-1:0] raw_in, syn;
  cpd_pres_t        pres;
  logic             chg_flag, pulse_busy;

  assign raw_in = {io_rdy, card_rdy, det2_n, det1_n};

  cpd_sync #(
    .WIDTH  (NSYNC),
    .STAGES (SYNC_STAGES),
    .RST_VAL(4'b0011)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (raw_in),
    .q    (syn)
  );

  cpd_presence #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_pres (
    .clk     (clk),
    .rst_n   (rst_n),
    .det1_s  (syn[0]),
    .det2_s  (syn[1]),
    .chg_clr (chg_clr),
    .pres    (pres),
    .chg_flag(chg_flag)
  );

  cpd_rst_timer #(
    .RST_CYCLES(RST_CYCLES)
  ) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .start(pres.insert),
    .abort(pres.remove),
    .busy (pulse_busy)
  );

  always_comb begin
    status            = '0;
    status[STS_CHG]   = chg_flag;
    status[STS_DET1]  = syn[0];
    status[STS_DET2]  = syn[1];
    status[STS_CRDY]  = syn[2];
    status[STS_IORDY] = syn[3];
  end

  assign card_present = pres.present;
  assign det_event    = pres.change;
  assign card_reset   = pulse_busy | sw_rst_req;

  // R6: software request always reaches the card reset
  p_sw_forces_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst_req |-> card_reset);

  // R5: every event leaves the sticky flag set
  p_chg_on_event_r5: assert property (@(posedge clk) disable iff (!rst_n)
    det_event |-> status[STS_CHG]);

  // R2: a reset pulse follows an insertion event
  p_pulse_after_insert_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (det_event && card_present) |=> card_reset);
endmodule

// File: tb/cpd_card_detect_test.sv
module cpd_card_detect_test;
  localparam time PERIOD = 10ns;
  localparam int  RST    = 12;

  logic       clk = 1'b0;
  logic       rst_n, det1_n, det2_n, card_rdy, io_rdy, sw_rst_req, chg_clr;
  logic       card_present, det_event, card_reset;
  logic [7:0] status;
  int         n_chk = 0;
  int         n_bad = 0;

  always #(PERIOD/2) clk = ~clk;

  cpd_card_detect #(
    .CLK_HZ(1_000_000), .PULSE_US(RST), .SYNC_STAGES(2)
  ) uut (
    .clk(clk), .rst_n(rst_n), .det1_n(det1_n), .det2_n(det2_n),
    .card_rdy(card_rdy), .io_rdy(io_rdy), .sw_rst_req(sw_rst_req),
    .chg_clr(chg_clr), .card_present(card_present), .det_event(det_event),
    .card_reset(card_reset), .status(status)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #(PERIOD * 190000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; det1_n = 1'b1; det2_n = 1'b1; card_rdy = 1'b0; io_rdy = 1'b0;
    sw_rst_req = 1'b0; chg_clr = 1'b0;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 present", card_present, 0);
    check("R9 event", det_event, 0);
    check("R9 reset", card_reset, 0);
    check("R9 status", status, 8'h0C);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R1 R2 R3 R4 R5: all old/new pin pairs
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        logic pa, pb, ins;
        int   highs;
        {det2_n, det1_n} = a[1:0];
        repeat (RST + 8) @(negedge clk);
        chg_clr = 1'b1;
        @(negedge clk);
        chg_clr = 1'b0;
        pa  = (a == 0);
        pb  = (b == 0);
        ins = pb && !pa;
        {det2_n, det1_n} = b[1:0];
        repeat (2) @(negedge clk);
        check("R5 det1 bit", status[2], b[0]);
        check("R5 det2 bit", status[3], b[1]);
        check("R4 not early", card_present, pa);
        @(negedge clk);
        check("R1 present", card_present, pb);
        check("R3 event", det_event, pa != pb);
        check("R5 change flag", status[0], pa != pb);
        highs = 0;
        for (int k = 0; k < RST + 3; k++) begin
          @(negedge clk);
          if (k == 0) begin
            check("R3 single cycle", det_event, 0);
            check("R2 pulse start", card_reset, ins);
          end
          if (card_reset) highs++;
        end
        check("R2 pulse length", highs, ins ? RST : 0);
      end
    end

    // R5 clear and set-wins
    check("R5 sticky", status[0], 0);
    {det2_n, det1_n} = 2'b00;
    repeat (3) @(negedge clk);
    check("R5 set", status[0], 1);
    chg_clr = 1'b1;
    @(negedge clk);
    chg_clr = 1'b0;
    check("R5 cleared", status[0], 0);
    repeat (RST + 4) @(negedge clk);
    {det2_n, det1_n} = 2'b11;
    repeat (2) @(negedge clk);
    chg_clr = 1'b1;
    @(negedge clk);
    chg_clr = 1'b0;
    check("R5 set wins", status[0], 1);
    check("R3 removal event", det_event, 1);

    // R5 ready bits and reserved zeros
    for (int v = 0; v < 4; v++) begin
      {io_rdy, card_rdy} = v[1:0];
      repeat (2) @(negedge clk);
      check("R5 card ready", status[5], v[0]);
      check("R5 io ready", status[6], v[1]);
      check("R5 reserved", {status[7], status[4], status[1]}, 0);
    end

    // R6 software request
    repeat (4) @(negedge clk);
    sw_rst_req = 1'b1;
    #1 check("R6 forced", card_reset, 1);
    @(negedge clk);
    sw_rst_req = 1'b0;
    #1 check("R6 released", card_reset, 0);

    // R7 removal during pulse
    @(negedge clk);
    {det2_n, det1_n} = 2'b00;
    repeat (3) @(negedge clk);
    @(negedge clk);
    check("R7 pulse running", card_reset, 1);
    repeat (3) @(negedge clk);
    {det2_n, det1_n} = 2'b10;
    repeat (3) @(negedge clk);
    check("R7 removal event", det_event, 1);
    @(negedge clk);
    check("R7 pulse ended", card_reset, 0);

    // R8 card seated through controller reset
    repeat (RST + 4) @(negedge clk);
    {det2_n, det1_n} = 2'b00;
    repeat (RST + 6) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    begin
      int evs, rsts;
      evs = 0; rsts = 0;
      for (int k = 0; k < RST + 4; k++) begin
        @(negedge clk);
        if (det_event) evs++;
        if (card_reset) rsts++;
      end
      check("R8 present", card_present, 1);
      check("R8 no event", evs, 0);
      check("R8 no pulse", rsts, 0);
    end
    {det2_n, det1_n} = 2'b01;
    repeat (3) @(negedge clk);
    check("R8 armed after settle", det_event, 1);

    summary();
    $finish;
  end
endmodule